// File: doc/BRIEF.md
# Write-Once Configuration Register Pair

This block keeps two byte-wide option registers on a simple processor bus. The bus has an address, a write strobe with write data, and a read strobe with read data. After each reset, software gets one write to each register. Any later write to that register is dropped until the next reset. Both registers can be read back at any time. The decoded option bits leave the block as plain outputs. They set the watchdog rate, the voltage-monitor options and the stop-mode options of the surrounding chip.

There are two synchronous active-low resets: a general reset and a power-on reset. A few voltage-monitor bits are bound to power-on only. They are the power-down bit and the two trip-level bits. They keep their value through a general reset, and they accept only one write per power-on cycle. A power-on reset also acts as a general reset.

The block also turns the rate-select bit into a ready-made watchdog timeout length that a counter can load. It masks the stop-mode monitor enable with the power-down bit.

Top module: `cfg_once_regs`

## Requirements
- R1: Register A is at address 0x001F and register B at 0x001D. While `rd_en` is high and the address matches, `rd_data` shows that register. For any other address, or with `rd_en` low, `rd_data` is 0.
- R2: After any reset, the first write (`wr_en` high, matching address) to a register is accepted. Every later write to the same register leaves its contents unchanged until the next reset.
- R3: A general reset (`rst_n` low, `por_n` high) clears every bit except the power-on-only bits and re-arms the one-write permission of both registers. The power-on-only bits are register A bit 4 and register B bits 1:0.
- R4: A power-on reset (`por_n` low) clears every bit of both registers and re-arms both the per-reset and the power-on write permissions.
- R5: The power-on-only bits accept one write per power-on cycle. Suppose the first write after a general reset comes when their power-on write has already been used. Then the other bits of that write are taken, the power-on-only bits keep their old value, and the register is still locked.
- R6: Register A bit 3 is reserved. It always reads 0 and ignores writes.
- R7: Register A bit fields are:
  - bit 7 `wdg_rate_sel`
  - bit 5 `vmon_rst_dis`
  - bit 4 `vmon_pwrdn`
  - bit 2 `fast_stop_rec`
  - bit 1 `stop_en`
  - bit 0 `wdg_dis`

  Register B bit fields are:
  - bits 7:2 `aux_opts`
  - bits 1:0 `vmon_trip`

  Each output equals its field.
- R8: `vmon_stop_eff` is register A bit 6 (stop-mode monitor enable) masked so that it is 1 only while bit 4 (power-down) is 0.
- R9: `wdg_timeout` is 8176 (2^13 − 2^4) when `wdg_rate_sel` is 1, and 262128 (2^18 − 2^4) when it is 0.
- R10: A write to any address other than the two register addresses changes no register and uses up no write permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | General reset, synchronous, active low |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| addr | input | 16 | Bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational |
| wdg_rate_sel | output | 1 | Watchdog short-timeout select |
| vmon_stop_eff | output | 1 | Effective stop-mode monitor enable |
| vmon_rst_dis | output | 1 | Monitor reset disable |
| vmon_pwrdn | output | 1 | Monitor power-down |
| fast_stop_rec | output | 1 | Short stop-recovery |
| stop_en | output | 1 | Stop enable |
| wdg_dis | output | 1 | Watchdog disable |
| vmon_trip | output | 2 | Monitor trip level |
| aux_opts | output | 6 | General options of register B |
| wdg_timeout | output | 18 | Watchdog timeout length in clock cycles |

## Verification
Random writes, some to the two register addresses and some to unmapped ones, are mixed with random general and power-on resets. This tells first-write acceptance apart from later-write rejection, and also separates the two reset kinds by what each keeps.

Directed cases cover three situations:
- A write that changes power-on-only bits while their power-on permission is already used. This separates the power-on lock from the per-reset lock.
- Writes of all ones, which probe the reserved bit.
- Both rate settings, which check the two timeout constants.

// File: rtl/cfg_once_pkg.sv
// Package: bit positions and masks of the two write-once option registers.
// Assumes byte-wide registers; the positions are what the output decode uses.
package cfg_once_pkg;
    localparam int DATA_W = 8;

    // Register A field positions
    localparam int A_RATE   = 7;
    localparam int A_STOPEN = 6;
    localparam int A_RSTDIS = 5;
    localparam int A_PWRDN  = 4;
    localparam int A_RSVD   = 3;
    localparam int A_FSTREC = 2;
    localparam int A_STOP   = 1;
    localparam int A_WDGDIS = 0;

    // Register B field positions
    localparam int B_TRIP_LO = 0;
    localparam int B_TRIP_W  = 2;
    localparam int B_AUX_LO  = 2;
    localparam int B_AUX_W   = 6;

    // Bits bound to power-on reset, and reserved bits
    localparam logic [DATA_W-1:0] A_POR_MASK  = DATA_W'(1) << A_PWRDN;
    localparam logic [DATA_W-1:0] A_RSVD_MASK = DATA_W'(1) << A_RSVD;
    localparam logic [DATA_W-1:0] B_POR_MASK  = ((DATA_W'(1) << B_TRIP_W) - DATA_W'(1)) << B_TRIP_LO;
    localparam logic [DATA_W-1:0] B_RSVD_MASK = '0;
endpackage

// File: rtl/cfg_once_cell.sv
// Module: one write-once register with two locks.
// The per-reset lock re-arms on either reset. The power-on lock guards the
// bits in POR_MASK and re-arms only on power-on reset. Bits in RSVD_MASK stay 0.
// Assumes synchronous active-low resets; por_n low overrides rst_n.
module cfg_once_cell #(
    parameter int                W         = 8,
    parameter logic [W-1:0]      POR_MASK  = '0,
    parameter logic [W-1:0]      RSVD_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         por_n,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] GEN_MASK = ~(POR_MASK | RSVD_MASK);

    logic lock_q;
    logic plock_q;

    // Register contents and both locks, with the two reset rules
    always_ff @(posedge clk) begin
        if (!por_n) begin
            q       <= '0;
            lock_q  <= 1'b0;
            plock_q <= 1'b0;
        end else if (!rst_n) begin
            q      <= q & POR_MASK;
            lock_q <= 1'b0;
        end else if (wr_sel && !lock_q) begin
            lock_q  <= 1'b1;
            plock_q <= 1'b1;
            q       <= (wr_data & GEN_MASK)
                     | ((plock_q ? q : wr_data) & POR_MASK);
        end
    end

    // R2: once locked, contents hold until a reset
    a_r2_locked_hold: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        lock_q |=> $stable(q));

    // R3: a general reset keeps the power-on-only bits
    a_r3_keep_por_bits: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> ((q & POR_MASK) == $past(q & POR_MASK)));

    // R4: contents are zero right after power-on reset releases
    a_r4_por_clear: assert property (@(posedge clk) disable iff (!por_n)
        !$past(por_n) |-> (q == '0));

    // R5: power-on lock freezes the power-on-only bits across general resets
    a_r5_por_lock_hold: assert property (@(posedge clk) disable iff (!por_n)
        plock_q |=> ((q & POR_MASK) == $past(q & POR_MASK)));

    // R6: reserved bits never become 1 after power-on reset
    a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (!por_n)
        wr_sel |=> ((q & RSVD_MASK) == '0));
endmodule

// File: rtl/cfg_once_tmo.sv
// Module: turns the rate select into a watchdog timeout length.
// The length is 2^SHORT_EXP - 2^TRIM_EXP when fast is set, otherwise
// 2^LONG_EXP - 2^TRIM_EXP. Assumes TRIM_EXP < SHORT_EXP < LONG_EXP.
module cfg_once_tmo #(
    parameter int SHORT_EXP = 13,
    parameter int LONG_EXP  = 18,
    parameter int TRIM_EXP  = 4,
    localparam int TMO_W    = LONG_EXP
) (
    input  logic             fast,
    output logic [TMO_W-1:0] tmo
);
    localparam logic [TMO_W-1:0] SHORT_TMO = TMO_W'((64'd1 << SHORT_EXP) - (64'd1 << TRIM_EXP));
    localparam logic [TMO_W-1:0] LONG_TMO  = TMO_W'((64'd1 << LONG_EXP)  - (64'd1 << TRIM_EXP));

    // Pick the timeout constant from the rate select
    always_comb tmo = fast ? SHORT_TMO : LONG_TMO;
endmodule

// File: rtl/cfg_once_regs.sv
// Module: two write-once option registers on a simple bus, with decoded outputs.
// Register A holds watchdog and monitor options; register B holds general
// options and the monitor trip level. Read data is combinational.
// Assumes synchronous active-low resets; a power-on reset also acts as general reset.
module cfg_once_regs
    import cfg_once_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] REG_A_ADDR = 16'h001F,
    parameter logic [ADDR_W-1:0] REG_B_ADDR = 16'h001D,
    parameter int                SHORT_EXP = 13,
    parameter int                LONG_EXP  = 18,
    parameter int                TRIM_EXP  = 4,
    localparam int               TMO_W     = LONG_EXP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    output logic                wdg_rate_sel,
    output logic                vmon_stop_eff,
    output logic                vmon_rst_dis,
    output logic                vmon_pwrdn,
    output logic                fast_stop_rec,
    output logic                stop_en,
    output logic                wdg_dis,
    output logic [B_TRIP_W-1:0] vmon_trip,
    output logic [B_AUX_W-1:0]  aux_opts,
    output logic [TMO_W-1:0]    wdg_timeout
);
    logic              hit_a;
    logic              hit_b;
    logic [DATA_W-1:0] reg_a;
    logic [DATA_W-1:0] reg_b;

    // Address decode shared by reads and writes
    always_comb begin
        hit_a = (addr == REG_A_ADDR);
        hit_b = (addr == REG_B_ADDR);
    end

    cfg_once_cell #(
        .W(DATA_W), .POR_MASK(A_POR_MASK), .RSVD_MASK(A_RSVD_MASK)
    ) u_reg_a (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_sel(wr_en && hit_a), .wr_data(wr_data), .q(reg_a)
    );

    cfg_once_cell #(
        .W(DATA_W), .POR_MASK(B_POR_MASK), .RSVD_MASK(B_RSVD_MASK)
    ) u_reg_b (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr_sel(wr_en && hit_b), .wr_data(wr_data), .q(reg_b)
    );

    cfg_once_tmo #(
        .SHORT_EXP(SHORT_EXP), .LONG_EXP(LONG_EXP), .TRIM_EXP(TRIM_EXP)
    ) u_tmo (
        .fast(reg_a[A_RATE]), .tmo(wdg_timeout)
    );

    // Read mux: zero unless strobed at a mapped address
    always_comb begin
        rd_data = '0;
        if (rd_en && hit_a)      rd_data = reg_a;
        else if (rd_en && hit_b) rd_data = reg_b;
    end

    // Field decode to option outputs
    always_comb begin
        wdg_rate_sel  = reg_a[A_RATE];
        vmon_stop_eff = reg_a[A_STOPEN] & ~reg_a[A_PWRDN];
        vmon_rst_dis  = reg_a[A_RSTDIS];
        vmon_pwrdn    = reg_a[A_PWRDN];
        fast_stop_rec = reg_a[A_FSTREC];
        stop_en       = reg_a[A_STOP];
        wdg_dis       = reg_a[A_WDGDIS];
        vmon_trip     = reg_b[B_TRIP_LO +: B_TRIP_W];
        aux_opts      = reg_b[B_AUX_LO +: B_AUX_W];
    end

    // R8: the effective stop-mode enable is never on while powered down
    a_r8_stop_masked: assert property (@(posedge clk) disable iff (!por_n)
        vmon_stop_eff |-> !vmon_pwrdn);

    // R10: a write to an unmapped address leaves both registers unchanged
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && !hit_a && !hit_b) |=> ($stable(reg_a) && $stable(reg_b)));
endmodule

// File: tb/test_cfg_once_regs.sv
// Bench: random writes, resets and reads mixed with directed corners,
// checked against a bench-side model of both registers and their locks.
module test_cfg_once_regs;
    logic        clk = 1'b0;
    logic        rst_n, por_n, wr_en, rd_en;
    logic [15:0] addr;
    logic [7:0]  wr_data, rd_data;
    logic        wdg_rate_sel, vmon_stop_eff, vmon_rst_dis, vmon_pwrdn;
    logic        fast_stop_rec, stop_en, wdg_dis;
    logic [1:0]  vmon_trip;
    logic [5:0]  aux_opts;
    logic [17:0] wdg_timeout;

    int vecs = 0;
    int miss = 0;

    // model state
    logic [7:0] ma, mb;
    bit la, lb, pa, pb;

    localparam logic [7:0] A_POR = 8'h10, A_GEN = 8'hE7, B_POR = 8'h03, B_GEN = 8'hFC;

    always #10 clk = ~clk;

    cfg_once_regs i_cfg_once_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .wdg_rate_sel(wdg_rate_sel), .vmon_stop_eff(vmon_stop_eff),
        .vmon_rst_dis(vmon_rst_dis), .vmon_pwrdn(vmon_pwrdn),
        .fast_stop_rec(fast_stop_rec), .stop_en(stop_en), .wdg_dis(wdg_dis),
        .vmon_trip(vmon_trip), .aux_opts(aux_opts), .wdg_timeout(wdg_timeout)
    );

    function automatic logic [7:0] merge(logic [7:0] old, logic [7:0] d,
                                         logic [7:0] gen, logic [7:0] por, bit plk);
        return (d & gen) | ((plk ? old : d) & por);
    endfunction

    function automatic logic [17:0] exp_tmo(logic fast);
        return fast ? 18'd8176 : 18'd262128;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_write(logic [15:0] a, logic [7:0] d);
        if (a == 16'h001F && !la) begin
            ma = merge(ma, d, A_GEN, A_POR, pa); la = 1; pa = 1;
        end else if (a == 16'h001D && !lb) begin
            mb = merge(mb, d, B_GEN, B_POR, pb); lb = 1; pb = 1;
        end
    endtask

    task automatic do_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic gen_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        ma &= A_POR; mb &= B_POR; la = 0; lb = 0;
    endtask

    task automatic pwr_reset();
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        ma = 0; mb = 0; la = 0; lb = 0; pa = 0; pb = 0;
    endtask

    task automatic check_all(string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = 16'h001F; #2;
        chk("R1", {tag, " read A"}, rd_data, ma);
        chk("R6", {tag, " reserved bit"}, rd_data[3], 1'b0);
        addr = 16'h001D; #2;
        chk("R1", {tag, " read B"}, rd_data, mb);
        addr = 16'h001E; #2;
        chk("R1", {tag, " unmapped read"}, rd_data, 8'h00);
        rd_en = 1'b0; addr = 16'h001F; #2;
        chk("R1", {tag, " no strobe"}, rd_data, 8'h00);
        chk("R7", {tag, " fields A"},
            {wdg_rate_sel, vmon_rst_dis, vmon_pwrdn, fast_stop_rec, stop_en, wdg_dis},
            {ma[7], ma[5], ma[4], ma[2], ma[1], ma[0]});
        chk("R7", {tag, " fields B"}, {aux_opts, vmon_trip}, mb);
        chk("R8", {tag, " stop enable"}, vmon_stop_eff, ma[6] & ~ma[4]);
        chk("R9", {tag, " timeout"}, wdg_timeout, exp_tmo(ma[7]));
    endtask

    // watchdog
    initial begin
        #(20 * 150000);
        miss++;
        $display("FAIL watchdog all act=hung exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        void'($urandom(32'd7715));
        rst_n = 1'b0; por_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wr_data = '0;
        ma = 0; mb = 0; la = 0; lb = 0; pa = 0; pb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        check_all("R4 reset state");

        // R2/R6: first write taken, second ignored; reserved bit stays 0
        do_write(16'h001F, 8'hFF);
        check_all("R2 first write A");
        do_write(16'h001F, 8'h00);
        check_all("R2 second write A");
        do_write(16'h001D, 8'hA6);
        do_write(16'h001D, 8'h59);
        check_all("R2 write B");

        // R3/R5: general reset keeps power-on bits; new write cannot change them
        gen_reset();
        check_all("R3 after general reset");
        do_write(16'h001F, 8'h41);
        check_all("R5 power-on bit kept");
        do_write(16'h001F, 8'h80);
        check_all("R5 lock still set");
        do_write(16'h001D, 8'h00);
        check_all("R5 trip kept");

        // R10: unmapped write leaves permission intact
        pwr_reset();
        do_write(16'h001E, 8'hFF);
        check_all("R10 unmapped write");
        do_write(16'h001F, 8'h40);
        check_all("R8 stop enable without power-down");
        do_write(16'h001D, 8'h02);
        check_all("R10 permission kept");

        // R9: both rate settings after power-on
        pwr_reset();
        check_all("R4 power-on clears");
        do_write(16'h001F, 8'h80);
        check_all("R9 short timeout");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 99);
            if (op < 70) begin
                int s = $urandom_range(0, 4);
                logic [15:0] a = (s < 2) ? 16'h001F : (s < 4) ? 16'h001D : 16'($urandom);
                do_write(a, 8'($urandom));
            end else if (op < 92) begin
                gen_reset();
            end else begin
                pwr_reset();
            end
            check_all("R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule